// File: doc/BRIEF.md
# Cascade-Gated Countdown Timer

This block is one down-counting timer channel. Software programs a reload value and a current count through a small write port, then sets the enable bit. The counter steps down by one on each clock while it runs. When it runs at a count of zero it emits a one-cycle timeout pulse and reloads, so the period is the reload value plus one. An interrupt pulse goes with each timeout when interrupts are enabled. Two control bits change what happens at zero. Auto-disable stops the timer completely. Auto-deactivate drops only the running state, so the timer waits for its start condition again.

Running can be qualified by three cascade signals. Each is taken from a wide bus of candidate signals through an 8-bit selector code, synchronized by two flops, and optionally inverted. Cascades 0 and 1 are start/run qualifiers. They can be combined by AND or OR, and either can be a one-shot trigger that is disregarded once the timer is running. Cascade 2 is a stop source. Either it pauses counting while it is active, or, in its trigger form, it switches the timer off at the moment the count hits zero.

Top module: `cascade_timer`

## Requirements
- R1: After reset the count, enable, active, timeout and interrupt outputs are all 0.
- R2: The write port decodes wr_addr as 0 control, 1 reload value, 2 count, 3 cascade control, 4/5/6 selectors of cascades 0/1/2 (bits 7:0). A write to address 2 loads the count directly. A software write takes priority over the counter's own update in the same cycle.
- R3: Control bit 0 is enable. Writing it with 1 arms the timer; the active bit rises one cycle later if the start condition holds. Writing it with 0 clears both enable and active.
- R4: While enabled and active, the count drops by one per cycle. At zero it reloads and timeout_o pulses for one cycle. With no cascades, the first pulse comes reload+2 cycles after the enabling write, then every reload+1 cycles.
- R5: irq_o pulses together with timeout_o only when control bit 1 (interrupt enable) is set.
- R6: With control bit 2 (auto-disable) set, the zero event clears both enable and active, regardless of bit 3.
- R7: With control bit 3 (auto-deactivate) set and bit 2 clear, the zero event clears active and keeps enable. The timer restarts one cycle later when its start condition holds.
- R8: Control bit 4 (stop request) freezes the count and blocks starting while it is set.
- R9: Cascade control bits 0/2 enable cascades 0/1 as run qualifiers, and bits 1/3 invert them. An enabled, non-trigger qualifier that goes inactive freezes the count while the timer stays active.
- R10: When cascades 0 and 1 are both enabled, cascade control bit 4 combines them: 0 means AND, 1 means OR.
- R11: Cascade control bits 5/6 put cascade 0/1 in trigger mode. The qualifier only has to be active to start, and is ignored while the timer is active.
- R12: Cascade control bit 7 enables cascade 2 and bit 8 inverts it. With bit 9 clear, an active cascade 2 freezes the count like the stop request.
- R13: With cascade control bits 7 and 9 set, an active cascade 2 at the zero event clears enable and active. At any nonzero count it has no effect.
- R14: A selector code picks src_bus bit of that index (port A pins from 0, port B from 32, timer outputs from 64, memory errors 96 to 99, event line 100, clock-divider outputs from 120). Codes at or above SRC_N read as 0. Cascades pass a two-flop synchronizer before inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | CNT_W | Write data |
| src_bus | input | SRC_N | Candidate cascade source signals |
| count_o | output | CNT_W | Current count |
| enable_o | output | 1 | Enable bit |
| active_o | output | 1 | Active (running) bit |
| timeout_o | output | 1 | One-cycle pulse on each zero event |
| irq_o | output | 1 | Timeout pulse gated by interrupt enable |

## Verification
The assertions assume that a selector code changes only while the timer is disabled. This matters because a changing mux in front of the synchronizer can let a stale level through for two cycles. They also assume that the cascade sources hold each level for at least two clocks. The stimulus drives every input on the falling edge. It reprograms selectors and cascade control only after writing enable to 0. After each source change it waits several cycles before it reads the count, so the two-cycle synchronizer delay never falls inside a checked window.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
  localparam int SEL_W = 8;
  localparam int SEL_SPAN = 1 << SEL_W;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_RELOAD = 3'd1,
    A_COUNT  = 3'd2,
    A_CSD    = 3'd3,
    A_SEL0   = 3'd4,
    A_SEL1   = 3'd5,
    A_SEL2   = 3'd6
  } reg_addr_e;

  // bit 0 is c0_en ... bit 9 is c2_trig (first field is the MSB)
  typedef struct packed {
    logic c2_trig;
    logic c2_inv;
    logic c2_en;
    logic c1_trig;
    logic c0_trig;
    logic dual_or;
    logic c1_inv;
    logic c1_en;
    logic c0_inv;
    logic c0_en;
  } csd_cfg_t;

  typedef struct packed {
    logic stop_req;
    logic auto_deact;
    logic auto_dis;
    logic irq_en;
  } ctl_bits_t;

  // Merge two qualifier levels; a disabled qualifier imposes nothing.
  function automatic logic pair_combine(input logic en0, input logic en1,
                                        input logic v0, input logic v1,
                                        input logic use_or);
    if (en0 && en1) return use_or ? (v0 | v1) : (v0 & v1);
    if (en0) return v0;
    if (en1) return v1;
    return 1'b1;
  endfunction

  // Next count value while running: reload on zero, else step down.
  function automatic logic [63:0] next_count(input logic [63:0] cur, input logic [63:0] rl);
    return (cur == 64'd0) ? rl : cur - 64'd1;
  endfunction
endpackage

// File: rtl/cascade_path.sv
module cascade_path
  import cascade_timer_pkg::*;
#(
  parameter int SRC_N = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_bus,
  input  logic [SEL_W-1:0] sel,
  input  logic             inv,
  output logic             lvl
);
  logic [SEL_SPAN-1:0] src_ext;
  logic                picked;
  logic                sync1_q, sync2_q;

  generate
    if (SRC_N < SEL_SPAN) begin : g_pad
      assign src_ext = {{(SEL_SPAN-SRC_N){1'b0}}, src_bus};
    end else begin : g_trim
      assign src_ext = src_bus[SEL_SPAN-1:0];
    end
  endgenerate

  assign picked = src_ext[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= picked;
      sync2_q <= sync1_q;
    end
  end

  assign lvl = sync2_q ^ inv;
endmodule

// File: rtl/cascade_qual.sv
module cascade_qual
  import cascade_timer_pkg::*;
(
  input  csd_cfg_t   cfg,
  input  logic [2:0] lvl,
  output logic       start_ok,
  output logic       gate_ok,
  output logic       stop_lvl,
  output logic       halt_arm
);
  logic run0, run1;

  // Trigger-mode qualifiers no longer matter once running
  assign run0 = cfg.c0_trig ? 1'b1 : lvl[0];
  assign run1 = cfg.c1_trig ? 1'b1 : lvl[1];

  assign start_ok = pair_combine(cfg.c0_en, cfg.c1_en, lvl[0], lvl[1], cfg.dual_or);
  assign gate_ok  = pair_combine(cfg.c0_en, cfg.c1_en, run0, run1, cfg.dual_or);
  assign stop_lvl = cfg.c2_en & ~cfg.c2_trig & lvl[2];
  assign halt_arm = cfg.c2_en & cfg.c2_trig & lvl[2];
endmodule

// File: rtl/timer_core.sv
module timer_core
  import cascade_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [4:0]       ctrl_data,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_data,
  input  logic [CNT_W-1:0] reload,
  input  logic             start_ok,
  input  logic             gate_ok,
  input  logic             stop_lvl,
  input  logic             halt_arm,
  output logic [CNT_W-1:0] count_o,
  output logic             enable_o,
  output logic             active_o,
  output logic             timeout_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q;
  logic             enable_q, active_q, timeout_q, irq_q;
  ctl_bits_t        ctl_q;
  logic             stop_w, run_w, zero_hit_w, start_w, kill_w, deact_w;

  assign stop_w     = ctl_q.stop_req | stop_lvl;
  assign run_w      = enable_q & active_q & gate_ok & ~stop_w;
  assign zero_hit_w = run_w & (count_q == '0);
  assign start_w    = enable_q & ~active_q & start_ok & ~stop_w;
  assign kill_w     = zero_hit_w & (ctl_q.auto_dis | halt_arm);
  assign deact_w    = zero_hit_w & ctl_q.auto_deact;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      enable_q  <= 1'b0;
      active_q  <= 1'b0;
      timeout_q <= 1'b0;
      irq_q     <= 1'b0;
      ctl_q     <= '0;
    end else begin
      timeout_q <= zero_hit_w;
      irq_q     <= zero_hit_w & ctl_q.irq_en;
      if (cnt_wr) count_q <= cnt_data;
      else if (run_w) count_q <= CNT_W'(next_count(64'(count_q), 64'(reload)));
      if (ctrl_wr) begin
        ctl_q    <= ctl_bits_t'(ctrl_data[4:1]);
        enable_q <= ctrl_data[0];
        active_q <= ctrl_data[0] ? active_q : 1'b0;
      end else begin
        if (kill_w) enable_q <= 1'b0;
        if (kill_w || deact_w) active_q <= 1'b0;
        else if (start_w) active_q <= 1'b1;
      end
    end
  end

  assign count_o   = count_q;
  assign enable_o  = enable_q;
  assign active_o  = active_q;
  assign timeout_o = timeout_q;
  assign irq_o     = irq_q;

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_w && count_q != '0 && !cnt_wr) |-> count_q == $past(count_q) - 1'b1);
  // R4
  timeout_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_q |-> $past(count_q == '0));
  // R5
  irq_with_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> timeout_q);
  // R6
  auto_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(zero_hit_w && ctl_q.auto_dis && !ctrl_wr) |-> !enable_q && !active_q);
  // R7
  auto_deact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(zero_hit_w && ctl_q.auto_deact && !ctl_q.auto_dis && !halt_arm && !ctrl_wr)
    |-> enable_q && !active_q);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_w && !cnt_wr) |-> $stable(count_q));
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import cascade_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SRC_N = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [SRC_N-1:0] src_bus,
  output logic [CNT_W-1:0] count_o,
  output logic             enable_o,
  output logic             active_o,
  output logic             timeout_o,
  output logic             irq_o
);
  localparam int N_CSD = 3;

  logic [CNT_W-1:0] reload_q;
  csd_cfg_t         csd_q;
  logic [SEL_W-1:0] sel_q [N_CSD];
  logic [N_CSD-1:0] inv_w, lvl_w;
  logic             start_ok_w, gate_ok_w, stop_lvl_w, halt_arm_w;
  logic             ctrl_wr_w, cnt_wr_w;

  assign ctrl_wr_w = wr_en && (wr_addr == A_CTRL);
  assign cnt_wr_w  = wr_en && (wr_addr == A_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      csd_q    <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_RELOAD) reload_q <= wr_data;
      if (wr_addr == A_CSD) csd_q <= csd_cfg_t'(wr_data[9:0]);
    end
  end

  assign inv_w = {csd_q.c2_inv, csd_q.c1_inv, csd_q.c0_inv};

  for (genvar k = 0; k < N_CSD; k++) begin : g_csd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q[k] <= '0;
      else if (wr_en && (wr_addr == 3'(A_SEL0 + k))) sel_q[k] <= wr_data[SEL_W-1:0];
    end

    cascade_path #(.SRC_N(SRC_N)) u_path (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_bus (src_bus),
      .sel     (sel_q[k]),
      .inv     (inv_w[k]),
      .lvl     (lvl_w[k])
    );
  end

  cascade_qual u_qual (
    .cfg      (csd_q),
    .lvl      (lvl_w),
    .start_ok (start_ok_w),
    .gate_ok  (gate_ok_w),
    .stop_lvl (stop_lvl_w),
    .halt_arm (halt_arm_w)
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr_w),
    .ctrl_data (wr_data[4:0]),
    .cnt_wr    (cnt_wr_w),
    .cnt_data  (wr_data),
    .reload    (reload_q),
    .start_ok  (start_ok_w),
    .gate_ok   (gate_ok_w),
    .stop_lvl  (stop_lvl_w),
    .halt_arm  (halt_arm_w),
    .count_o   (count_o),
    .enable_o  (enable_o),
    .active_o  (active_o),
    .timeout_o (timeout_o),
    .irq_o     (irq_o)
  );

  // R3
  active_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> enable_o);
endmodule

// File: tb/cascade_timer_test.sv
module cascade_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int SRC_N = 128;

  typedef struct packed {
    int rl;
    int n;
    int ie;
    int exp_to;
  } vec_t;

  // reload, observed cycles, irq enable, expected timeout count
  localparam vec_t VECS [0:4] = '{
    '{3, 20, 1, 4},
    '{0, 10, 0, 9},
    '{7, 30, 1, 3},
    '{1,  9, 0, 4},
    '{5,  6, 1, 0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [SRC_N-1:0] src_bus = '0;
  logic [CNT_W-1:0] count_o;
  logic             enable_o, active_o, timeout_o, irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_timer #(.CNT_W(CNT_W), .SRC_N(SRC_N)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_bus(src_bus), .count_o(count_o), .enable_o(enable_o), .active_o(active_o),
    .timeout_o(timeout_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // disable, load reload and count, set cascade config
  task automatic setup(input int rl, input int cnt, input int csd);
    wr(3'd0, 0);
    wr(3'd1, rl);
    wr(3'd2, cnt);
    wr(3'd3, csd);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    tick(3);
    // R1 reset state
    chk("R1 count", int'(count_o), 0);
    chk("R1 enable", int'(enable_o), 0);
    chk("R1 active", int'(active_o), 0);
    chk("R1 timeout", int'(timeout_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    @(negedge clk); rst_n = 1'b1;
    tick(2);

    // R4 R5 period table
    for (int i = 0; i < 5; i++) begin
      int n_to, n_irq;
      n_to = 0; n_irq = 0;
      setup(VECS[i].rl, VECS[i].rl, 0);
      wr(3'd0, 1 | (VECS[i].ie << 1));
      for (int k = 0; k < VECS[i].n; k++) begin
        @(negedge clk);
        n_to += int'(timeout_o);
        n_irq += int'(irq_o);
      end
      chk("R4 timeout count", n_to, VECS[i].exp_to);
      chk("R5 irq count", n_irq, VECS[i].ie != 0 ? VECS[i].exp_to : 0);
    end

    // R2 direct count load while disabled; R3 disable clears active
    wr(3'd0, 0);
    chk("R3 active cleared", int'(active_o), 0);
    wr(3'd2, 16'h55);
    chk("R2 count load", int'(count_o), 16'h55);

    // R6 auto-disable (with auto-deactivate also set)
    setup(2, 2, 0);
    wr(3'd0, 1 | 4 | 8);
    tick(8);
    chk("R6 enable off", int'(enable_o), 0);
    chk("R6 active off", int'(active_o), 0);
    chk("R6 count reloaded", int'(count_o), 2);

    // R7 auto-deactivate
    setup(2, 2, 0);
    wr(3'd0, 1 | 8);
    tick(4);
    chk("R7 timeout", int'(timeout_o), 1);
    chk("R7 active off", int'(active_o), 0);
    chk("R7 enable kept", int'(enable_o), 1);
    tick(1);
    chk("R7 restart", int'(active_o), 1);

    // R8 stop request
    setup(1000, 1000, 0);
    wr(3'd0, 1);
    tick(3);
    wr(3'd0, 1 | 16);
    tick(2);
    c = int'(count_o);
    tick(4);
    chk("R8 frozen", int'(count_o), c);
    wr(3'd0, 1);
    tick(2);
    chk("R8 resumed", int'(count_o), c - 2);

    // R9 level qualifier on port A pin 5 (code 5)
    src_bus = '0;
    setup(1000, 1000, 1);
    wr(3'd4, 5);
    wr(3'd0, 1);
    tick(8);
    chk("R9 no start", int'(active_o), 0);
    chk("R9 held", int'(count_o), 1000);
    src_bus[5] = 1'b1;
    tick(6);
    chk("R9 started", int'(active_o), 1);
    c = int'(count_o);
    tick(3);
    chk("R9 counting", int'(count_o), c - 3);
    src_bus[5] = 1'b0;
    tick(5);
    c = int'(count_o);
    tick(5);
    chk("R9 gated", int'(count_o), c);
    chk("R9 still active", int'(active_o), 1);

    // R9 R14 inverted clock-divider 3 (code 123)
    src_bus = '0;
    setup(1000, 1000, 1 | 2);
    wr(3'd4, 123);
    tick(4);
    wr(3'd0, 1);
    tick(6);
    chk("R9 inverted start", int'(active_o), 1);
    src_bus[123] = 1'b1;
    tick(5);
    c = int'(count_o);
    tick(4);
    chk("R14 code 123 gates", int'(count_o), c);

    // R11 trigger mode
    src_bus = '0;
    setup(1000, 1000, 1 | 32);
    wr(3'd4, 5);
    wr(3'd0, 1);
    tick(6);
    chk("R11 waits", int'(active_o), 0);
    src_bus[5] = 1'b1;
    tick(2);
    src_bus[5] = 1'b0;
    tick(8);
    c = int'(count_o);
    tick(4);
    chk("R11 ignored once active", int'(count_o), c - 4);

    // R10 AND vs OR: port B pin 1 (33) high, timer 0 output (64) low
    src_bus = '0;
    src_bus[33] = 1'b1;
    setup(1000, 1000, 1 | 4);
    wr(3'd4, 33);
    wr(3'd5, 64);
    wr(3'd0, 1);
    tick(8);
    chk("R10 AND blocks", int'(active_o), 0);
    setup(1000, 1000, 1 | 4 | 16);
    wr(3'd0, 1);
    tick(8);
    chk("R10 OR starts", int'(active_o), 1);

    // R12 cascade 2 stop level on event line (100)
    src_bus = '0;
    setup(1000, 1000, 128);
    wr(3'd6, 100);
    wr(3'd0, 1);
    tick(4);
    c = int'(count_o);
    tick(3);
    chk("R12 runs", int'(count_o), c - 3);
    src_bus[100] = 1'b1;
    tick(5);
    c = int'(count_o);
    tick(4);
    chk("R12 stopped", int'(count_o), c);
    src_bus[100] = 1'b0;
    tick(5);
    chk("R12 resumed", int'(count_o != c), 1);

    // R13 cascade 2 trigger on RAM single-bit error (96)
    src_bus = '0;
    src_bus[96] = 1'b1;
    setup(5, 5, 128 | 512);
    wr(3'd6, 96);
    tick(4);
    wr(3'd0, 1);
    tick(3);
    chk("R13 nonzero no effect count", int'(count_o), 3);
    chk("R13 nonzero no effect enable", int'(enable_o), 1);
    tick(6);
    chk("R13 off at zero enable", int'(enable_o), 0);
    chk("R13 off at zero active", int'(active_o), 0);

    // R14 out-of-range code reads 0
    src_bus = '1;
    setup(1000, 1000, 1);
    wr(3'd4, 200);
    wr(3'd0, 1);
    tick(8);
    chk("R14 out of range", int'(active_o), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule